// File: doc/BRIEF.md
# Data-Strobe Character Transmitter

This block turns link-level requests into a serial stream on a two-wire Data/Strobe pair, one bit per clock. Four kinds of request feed it. A time code carries a byte. A flow-control token has no payload. A packet request carries either a data byte or an end marker for a good or a bad packet. Each request is encoded as a character. The character starts with a parity bit and a data/control flag, and its payload follows least significant bit first. The Strobe wire is driven so that Data XOR Strobe changes on every bit, which lets the far end recover the clock.

A request is served only at a character boundary. The block raises the matching acknowledge in the cycle whose closing clock edge takes the character. The requester holds its request and payload steady until it sees that acknowledge. When nothing is pending, the block sends fill characters (escape followed by flow token) so the line never stops toggling. The first character after enable always goes high is such a fill. Credit accounting, packet buffering and line drivers sit outside this block.

Top module: `ds_char_tx`

## Requirements
- R1: While `enable` is low, the clock edge drives `line_d` and `line_s` to 0, and all three acknowledges stay low.
- R2: On every clock edge where `enable` is high, `line_d XOR line_s` takes the opposite of its previous value.
- R3: The first character after `enable` rises is a fill, even if requests are pending. Its bit sequence is 0,1,1,1,0,1,0,0, and the first bit is out after the first enabled edge.
- R4: A control character has 4 bits: parity, flag=1, then a 2-bit code sent LSB first. The codes are flow token 00, end 01, error end 10 and escape 11. A data character has 10 bits: parity, flag=0, then 8 data bits sent LSB first.
- R5: The parity bit gives odd parity over three things: the payload bits of the previous character, the parity bit itself and the flag of the current character. The first character after enable treats the previous payload as zero.
- R6: A time code is an escape followed by a data character that carries `tc_val`, 14 bits in all.
- R7: Precedence is time code first, then flow token, then the packet request, then fill. At most one acknowledge is high, and only for the highest request that is pending.
- R8: An acknowledge is raised only while its request is high and only at a character boundary, so two acknowledges are never on adjacent cycles. Each acknowledge produces exactly one character, and the characters go out in acknowledge order.
- R9: With no request pending, the stream is back-to-back fill characters of 8 bits each.
- R10: `chr_kind` selects the packet character: 00 is a data byte from `chr_data`, 01 is end of packet, and 10 or 11 is error end of packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Link transmit enable; low forces the idle line |
| tc_req | input | 1 | Time-code request |
| tc_val | input | DATA_W | Time-code byte |
| tc_ack | output | 1 | Time code taken at this edge |
| fct_req | input | 1 | Flow-token request |
| fct_ack | output | 1 | Flow token taken at this edge |
| chr_req | input | 1 | Packet-character request |
| chr_kind | input | 2 | Packet character kind (R10) |
| chr_data | input | DATA_W | Data byte for kind 00 |
| chr_ack | output | 1 | Packet character taken at this edge |
| line_d | output | 1 | Data wire |
| line_s | output | 1 | Strobe wire |

## Verification
The bench decodes the serial stream on its own and checks parity across character boundaries. Parity seeded from the wrong character, or reset at every character, fails on escape pairs and on time codes with bytes 00 and FF. Requests are raised together as enable rises. A design that skips the forced first fill, or that serves a lower request first, gives the wrong first eight bits and a wrong acknowledge order. The bench also disables the link and enables it again. A strobe that does not return to the zero phase breaks the toggle rule on the first bit, and a lost or repeated acknowledge leaves characters unmatched in the expected queue.

// File: rtl/ds_tx_pkg.sv
`timescale 1ns/1ps
package ds_tx_pkg;
   typedef enum logic [1:0] {
      SEL_FILL = 2'd0,
      SEL_TC   = 2'd1,
      SEL_FCT  = 2'd2,
      SEL_CHR  = 2'd3
   } sel_e;

   localparam logic [1:0] CODE_FCT = 2'b00;
   localparam logic [1:0] CODE_EOP = 2'b01;
   localparam logic [1:0] CODE_EEP = 2'b10;
   localparam logic [1:0] CODE_ESC = 2'b11;

   localparam logic [1:0] KIND_DATA = 2'b00;
   localparam logic [1:0] KIND_EOP  = 2'b01;

   localparam int CTRL_LEN = 4;
endpackage

// File: rtl/ds_tx_arbiter.sv
`timescale 1ns/1ps
module ds_tx_arbiter
   import ds_tx_pkg::*;
#(
   parameter int NREQ = 3
) (
   input  logic            take,
   input  logic            force_fill,
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] ack,
   output sel_e            sel
);
   logic [NREQ:0]   blocked;
   logic [NREQ-1:0] gnt;

   assign blocked[0] = force_fill;
   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_chain
         assign gnt[i]         = req[i] & ~blocked[i];
         assign blocked[i + 1] = blocked[i] | req[i];
      end
   endgenerate

   assign ack = gnt & {NREQ{take}};

   always_comb begin
      if (gnt[0])      sel = SEL_TC;
      else if (gnt[1]) sel = SEL_FCT;
      else if (gnt[2]) sel = SEL_CHR;
      else             sel = SEL_FILL;
   end
endmodule

// File: rtl/ds_tx_encoder.sv
`timescale 1ns/1ps
module ds_tx_encoder
   import ds_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1,
   parameter int FRAME_W    = DATA_W + 6,
   parameter int CNT_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               take,
   input  sel_e               sel,
   input  logic [DATA_W-1:0]  tc_val,
   input  logic [1:0]         chr_kind,
   input  logic [DATA_W-1:0]  chr_data,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   len
);
   localparam int  DCHR_LEN = DATA_W + 2;
   localparam int  FILL_LEN = 2 * CTRL_LEN;
   localparam int  TC_LEN   = CTRL_LEN + DCHR_LEN;
   localparam logic PAR_SEED = ODD_PARITY;

   logic x_q;
   logic x_nx;

   function automatic logic [CTRL_LEN-1:0] mk_ctrl(input logic [1:0] code, input logic px);
      return {code, 1'b1, PAR_SEED ^ px ^ 1'b1};
   endfunction

   function automatic logic [DCHR_LEN-1:0] mk_data(input logic [DATA_W-1:0] val, input logic px);
      return {val, 1'b0, PAR_SEED ^ px};
   endfunction

   always_comb begin
      frame = '0;
      len   = CNT_W'(CTRL_LEN);
      x_nx  = x_q;
      case (sel)
         SEL_TC: begin
            frame[CTRL_LEN-1:0]      = mk_ctrl(CODE_ESC, x_q);
            frame[TC_LEN-1:CTRL_LEN] = mk_data(tc_val, ^CODE_ESC);
            len  = CNT_W'(TC_LEN);
            x_nx = ^tc_val;
         end
         SEL_FCT: begin
            frame[CTRL_LEN-1:0] = mk_ctrl(CODE_FCT, x_q);
            x_nx = ^CODE_FCT;
         end
         SEL_CHR: begin
            if (chr_kind == KIND_DATA) begin
               frame[DCHR_LEN-1:0] = mk_data(chr_data, x_q);
               len  = CNT_W'(DCHR_LEN);
               x_nx = ^chr_data;
            end else if (chr_kind == KIND_EOP) begin
               frame[CTRL_LEN-1:0] = mk_ctrl(CODE_EOP, x_q);
               x_nx = ^CODE_EOP;
            end else begin
               frame[CTRL_LEN-1:0] = mk_ctrl(CODE_EEP, x_q);
               x_nx = ^CODE_EEP;
            end
         end
         default: begin
            frame[CTRL_LEN-1:0]          = mk_ctrl(CODE_ESC, x_q);
            frame[FILL_LEN-1:CTRL_LEN]   = mk_ctrl(CODE_FCT, ^CODE_ESC);
            len  = CNT_W'(FILL_LEN);
            x_nx = ^CODE_FCT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       x_q <= 1'b0;
      else if (!enable) x_q <= 1'b0;
      else if (take)    x_q <= x_nx;
   end
endmodule

// File: rtl/ds_tx_shifter.sv
`timescale 1ns/1ps
module ds_tx_shifter #(
   parameter int FRAME_W = 14,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   len,
   output logic               take,
   output logic               first,
   output logic               cur_bit
);
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   rem_q;
   logic               started_q;

   assign take    = enable && (rem_q == '0);
   assign first   = !started_q;
   assign cur_bit = take ? frame[0] : sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         rem_q     <= '0;
         started_q <= 1'b0;
      end else if (!enable) begin
         sh_q      <= '0;
         rem_q     <= '0;
         started_q <= 1'b0;
      end else if (take) begin
         sh_q      <= frame >> 1;
         rem_q     <= len - 1'b1;
         started_q <= 1'b1;
      end else begin
         sh_q      <= sh_q >> 1;
         rem_q     <= rem_q - 1'b1;
      end
   end
endmodule

// File: rtl/ds_tx_linecode.sv
`timescale 1ns/1ps
module ds_tx_linecode (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cur_bit,
   output logic line_d,
   output logic line_s
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b0;
         line_s <= 1'b0;
      end else if (!enable) begin
         line_d <= 1'b0;
         line_s <= 1'b0;
      end else begin
         line_d <= cur_bit;
         line_s <= cur_bit ^ ~(line_d ^ line_s);
      end
   end
endmodule

// File: rtl/ds_char_tx.sv
`timescale 1ns/1ps
module ds_char_tx
   import ds_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tc_req,
   input  logic [DATA_W-1:0] tc_val,
   output logic              tc_ack,
   input  logic              fct_req,
   output logic              fct_ack,
   input  logic              chr_req,
   input  logic [1:0]        chr_kind,
   input  logic [DATA_W-1:0] chr_data,
   output logic              chr_ack,
   output logic              line_d,
   output logic              line_s
);
   localparam int FRAME_W = DATA_W + 2 + CTRL_LEN;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("ds_char_tx: DATA_W must lie in 2..32");
      end
   endgenerate

   logic               take;
   logic               first;
   logic               cur_bit;
   sel_e               sel;
   logic [2:0]         ack;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   len;

   ds_tx_arbiter #(.NREQ(3)) u_arb (
      .take       (take),
      .force_fill (first),
      .req        ({chr_req, fct_req, tc_req}),
      .ack        (ack),
      .sel        (sel)
   );

   assign tc_ack  = ack[0];
   assign fct_ack = ack[1];
   assign chr_ack = ack[2];

   ds_tx_encoder #(
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY),
      .FRAME_W    (FRAME_W),
      .CNT_W      (CNT_W)
   ) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .take     (take),
      .sel      (sel),
      .tc_val   (tc_val),
      .chr_kind (chr_kind),
      .chr_data (chr_data),
      .frame    (frame),
      .len      (len)
   );

   ds_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shf (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .frame   (frame),
      .len     (len),
      .take    (take),
      .first   (first),
      .cur_bit (cur_bit)
   );

   ds_tx_linecode u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .cur_bit (cur_bit),
      .line_d  (line_d),
      .line_s  (line_s)
   );
endmodule

// File: rtl/ds_char_tx_chk.sv
`timescale 1ns/1ps
module ds_char_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic tc_req,
   input logic fct_req,
   input logic chr_req,
   input logic tc_ack,
   input logic fct_ack,
   input logic chr_ack,
   input logic line_d,
   input logic line_s
);
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!line_d && !line_s)); // R1
   AST_NO_ACK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !(tc_ack || fct_ack || chr_ack)); // R1
   AST_LINE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> ((line_d ^ line_s) != $past(line_d ^ line_s))); // R2
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tc_ack, fct_ack, chr_ack})); // R7
   AST_FCT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      fct_ack |-> !tc_req); // R7
   AST_CHR_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      chr_ack |-> !(tc_req || fct_req)); // R7
   AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ack || fct_ack || chr_ack) |-> ((tc_ack && tc_req) || (fct_ack && fct_req) || (chr_ack && chr_req))); // R8
   AST_ACK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ack || fct_ack || chr_ack) |=> !(tc_ack || fct_ack || chr_ack)); // R8
endmodule

bind ds_char_tx ds_char_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .enable  (enable),
   .tc_req  (tc_req),
   .fct_req (fct_req),
   .chr_req (chr_req),
   .tc_ack  (tc_ack),
   .fct_ack (fct_ack),
   .chr_ack (chr_ack),
   .line_d  (line_d),
   .line_s  (line_s)
);

// File: tb/ds_char_tx_test.sv
`timescale 1ns/1ps
module ds_char_tx_test;
   localparam int DW = 8;
   localparam int T_FCT = 1, T_EOP = 2, T_EEP = 3, T_DATA = 4, T_TC = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          tc_req = 1'b0;
   logic [DW-1:0] tc_val = '0;
   logic          tc_ack;
   logic          fct_req = 1'b0;
   logic          fct_ack;
   logic          chr_req = 1'b0;
   logic [1:0]    chr_kind = 2'b00;
   logic [DW-1:0] chr_data = '0;
   logic          chr_ack;
   logic          line_d;
   logic          line_s;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   int ack_log[$];
   bit bq[$];
   bit prevx = 1'b0;
   bit esc_pend = 1'b0;
   bit last_xs = 1'b0;
   bit en_edge = 1'b0;
   int null_cnt = 0;
   int bits_on = 0;
   bit fb[8];
   bit tc_taken = 1'b0, fct_taken = 1'b0, chr_taken = 1'b0;
   int unsigned seed = 32'h1D5A0C37;
   bit done = 1'b0;

   ds_char_tx #(.DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .tc_req(tc_req), .tc_val(tc_val), .tc_ack(tc_ack),
      .fct_req(fct_req), .fct_ack(fct_ack),
      .chr_req(chr_req), .chr_kind(chr_kind), .chr_data(chr_data), .chr_ack(chr_ack),
      .line_d(line_d), .line_s(line_s)
   );

   always #2 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int chr_sym(input logic [1:0] k, input logic [DW-1:0] d);
      if (k == 2'b00) return T_DATA * 256 + int'(d);   // R10 data
      if (k == 2'b01) return T_EOP * 256;              // R10 end
      return T_EEP * 256;                              // R10 error end
   endfunction

   function automatic string sym_tag(input int s);
      case (s / 256)
         T_TC:   return "R6 time code";
         T_DATA: return "R4 data char";
         T_FCT:  return "R4 flow token";
         default: return "R10 packet marker";
      endcase
   endfunction

   task automatic emit(input int s);
      int e;
      if (s == 0) begin
         null_cnt++;
         return;
      end
      if (exp_q.size() == 0) begin
         check(1'b0, "R8 unexpected char", s, -1);
         return;
      end
      e = exp_q.pop_front();
      check(s == e, sym_tag(e), s, e);
   endtask

   task automatic take_bit(input bit b);
      int len;
      bit px;
      int code;
      int val;
      bq.push_back(b);
      if (bq.size() < 2) return;
      len = bq[1] ? 4 : DW + 2;
      if (bq.size() < len) return;
      px = 1'b0;
      val = 0;
      for (int i = 2; i < len; i++) px ^= bq[i];
      check((bq[0] ^ prevx ^ bq[1]) == 1'b1, "R5 odd parity", int'(bq[0]), int'(~(prevx ^ bq[1])));
      prevx = px;
      if (bq[1]) begin
         code = int'(bq[2]) + 2 * int'(bq[3]);
         if (esc_pend) begin
            esc_pend = 1'b0;
            if (code == 0) emit(0);
            else check(1'b0, "R4 control after escape", code, 0);
         end else if (code == 3) begin
            esc_pend = 1'b1;
         end else begin
            emit((code == 0 ? T_FCT : (code == 1 ? T_EOP : T_EEP)) * 256);
         end
      end else begin
         for (int i = 0; i < DW; i++) val |= int'(bq[2 + i]) << i;
         if (esc_pend) begin
            esc_pend = 1'b0;
            emit(T_TC * 256 + val);
         end else begin
            emit(T_DATA * 256 + val);
         end
      end
      bq.delete();
   endtask

   task automatic sample();
      bit xs;
      if (en_edge) begin
         xs = line_d ^ line_s;
         check(xs != last_xs, "R2 strobe toggle", int'(xs), int'(!last_xs));
         last_xs = xs;
         if (bits_on < 8) fb[bits_on] = line_d;
         bits_on++;
         take_bit(line_d);
      end else begin
         check(!line_d && !line_s, "R1 idle lines", int'({line_d, line_s}), 0);
         last_xs = 1'b0;
         bits_on = 0;
         bq.delete();
         prevx = 1'b0;
         esc_pend = 1'b0;
      end
      if (!(enable && rst_n))
         check(!(tc_ack || fct_ack || chr_ack), "R1 no ack while off", int'({tc_ack, fct_ack, chr_ack}), 0);
      if (tc_ack || fct_ack || chr_ack) begin
         check($countones({tc_ack, fct_ack, chr_ack}) == 1, "R7 single grant",
               $countones({tc_ack, fct_ack, chr_ack}), 1);
         if (tc_ack) begin
            check(tc_req, "R8 ack needs request", int'(tc_req), 1);
            exp_q.push_back(T_TC * 256 + int'(tc_val));
            ack_log.push_back(T_TC);
            tc_taken = 1'b1;
         end
         if (fct_ack) begin
            check(fct_req && !tc_req, "R7 flow token below time code", int'({tc_req, fct_req}), 1);
            exp_q.push_back(T_FCT * 256);
            ack_log.push_back(T_FCT);
            fct_taken = 1'b1;
         end
         if (chr_ack) begin
            check(chr_req && !tc_req && !fct_req, "R7 packet char lowest", int'({tc_req, fct_req, chr_req}), 1);
            exp_q.push_back(chr_sym(chr_kind, chr_data));
            ack_log.push_back(T_DATA);
            chr_taken = 1'b1;
         end
      end
      en_edge = enable && rst_n;
   endtask

   task automatic cyc();
      #1;
      sample();
      @(negedge clk);
      if (tc_taken)  begin tc_req = 1'b0;  tc_taken = 1'b0;  end
      if (fct_taken) begin fct_req = 1'b0; fct_taken = 1'b0; end
      if (chr_taken) begin chr_req = 1'b0; chr_taken = 1'b0; end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic check_first_fill(input string tag);
      bit pat[8] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
      for (int i = 0; i < 8; i++) check(fb[i] == pat[i], tag, int'(fb[i]), int'(pat[i]));
   endtask

   task automatic send_tc(input logic [DW-1:0] v);
      tc_val = v; tc_req = 1'b1;
      while (tc_req) cyc();
   endtask

   task automatic send_fct();
      fct_req = 1'b1;
      while (fct_req) cyc();
   endtask

   task automatic send_chr(input logic [1:0] k, input logic [DW-1:0] d);
      chr_kind = k; chr_data = d; chr_req = 1'b1;
      while (chr_req) cyc();
   endtask

   initial begin
      int n0;
      void'($urandom(seed));
      @(negedge clk);
      // R1: reset and disabled state
      run(4);
      rst_n = 1'b1;
      run(3);
      check(!line_d && !line_s, "R1 lines after reset", int'({line_d, line_s}), 0);

      // R3 and R7: all requests pending as the link is enabled
      tc_req = 1'b1; tc_val = 8'hA5;
      fct_req = 1'b1;
      chr_req = 1'b1; chr_kind = 2'b00; chr_data = 8'h3C;
      enable = 1'b1;
      ack_log.delete();
      run(60);
      check_first_fill("R3 first fill bit");
      check(ack_log.size() == 3, "R7 ack count", ack_log.size(), 3);
      if (ack_log.size() == 3) begin
         check(ack_log[0] == T_TC,   "R7 first grant", ack_log[0], T_TC);
         check(ack_log[1] == T_FCT,  "R7 second grant", ack_log[1], T_FCT);
         check(ack_log[2] == T_DATA, "R7 third grant", ack_log[2], T_DATA);
      end
      check(exp_q.size() == 0, "R8 all acked chars seen", exp_q.size(), 0);

      // R9: idle fill
      n0 = null_cnt;
      run(100);
      check(null_cnt - n0 >= 11, "R9 fill count", null_cnt - n0, 11);

      // R10, R6, R5: directed markers, time codes and data
      send_chr(2'b01, 8'h00);
      send_chr(2'b10, 8'h00);
      send_chr(2'b11, 8'h00);
      send_tc(8'hFF);
      send_tc(8'h00);
      send_chr(2'b00, 8'h80);
      send_chr(2'b00, 8'hFF);
      send_fct();
      run(30);
      check(exp_q.size() == 0, "R10 directed chars seen", exp_q.size(), 0);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         if (!tc_req && ($urandom % 16) == 0) begin
            tc_val = DW'($urandom); tc_req = 1'b1;
         end
         if (!fct_req && ($urandom % 8) == 0) fct_req = 1'b1;
         if (!chr_req && ($urandom % 2) == 0) begin
            chr_kind = 2'($urandom); chr_data = DW'($urandom); chr_req = 1'b1;
         end
         cyc();
      end
      while (tc_req || fct_req || chr_req) cyc();
      run(40);
      check(exp_q.size() == 0, "R8 random stream drained", exp_q.size(), 0);

      // R1, R3: disable and enable again
      enable = 1'b0;
      run(10);
      check(!line_d && !line_s, "R1 lines when disabled", int'({line_d, line_s}), 0);
      fct_req = 1'b1;
      enable = 1'b1;
      run(30);
      check_first_fill("R3 fill after re-enable");
      check(exp_q.size() == 0, "R8 token after re-enable", exp_q.size(), 0);
      n0 = null_cnt;
      run(40);
      check(null_cnt - n0 >= 4, "R9 fill after re-enable", null_cnt - n0, 4);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule